// File: doc/BRIEF.md
# Threshold Interrupt Persistence Unit

This block watches the channel-0 result of a light-to-digital converter and decides when to raise an interrupt toward the host. Each time an integration period ends, the new channel-0 value is compared against a programmable 16-bit window. A saturating counter tracks how many results in a row fell outside that window. When the count reaches the programmed persistence, an interrupt becomes pending. It drives an active-low pin until software acknowledges it.

Three interrupt styles are supported. In level mode, only the clear bit of a command byte removes the interrupt. In alert mode, the clear bit also works, and so does a successful alert-response read. During that read the block presents its own 7-bit bus address in the upper bits of the response byte. If arbitration is lost during the address phase, the interrupt stays pending. In forced mode, writing the control register raises the interrupt at once, and it is then handled the same way as an alert-mode interrupt.

The bus slave supplies the strobes for the clear request, the control-register write and the end of the alert-response read. The register file supplies the threshold values and the control byte.

Top module: `thr_irq_unit`

## Requirements
- R1: A channel-0 value counts as out of window when it is less than or equal to the low threshold, or strictly greater than the high threshold. Values between those limits are in the window, and so is a value equal to the high threshold.
- R2: The consecutive-miss counter updates only on an end-of-integration strobe. It returns to zero on an in-window result and on a clear request. It saturates at 15 and does not wrap. It keeps counting while the output is disabled.
- R3: With persistence 0 (control bits 3:0), every end-of-integration strobe makes the interrupt pending, whatever the value and the thresholds are.
- R4: With persistence N from 1 to 15, the interrupt becomes pending on the strobe that completes N consecutive out-of-window results.
- R5: Apart from a forced write, a pending interrupt can only be set in the cycle of an end-of-integration strobe. Without a strobe, a forced write, a clear request or an alert-response read, the pending state never changes.
- R6: With mode 00 (control bits 5:4), the pin stays released (1) and strobes set no interrupt.
- R7: While an interrupt is pending and the mode is not 00, the pin is driven low one cycle after the setting event. It stays low until that interrupt is cleared. After reset the pin is 1.
- R8: If the control register is written with mode 11, the interrupt becomes pending on the following clock edge, with no strobe needed.
- R9: In modes 10 and 11, a completed alert-response read without arbitration loss clears a pending interrupt. A read flagged as lost leaves the interrupt pending. In mode 01 the alert-response read has no effect.
- R10: While an interrupt is pending in mode 10 or 11, the alert response byte equals the device address in bits 7:1 with bit 0 at 0. Otherwise the byte is 00h.
- R11: When a strobe that fires and a clear request fall in the same cycle, the interrupt remains pending. The counter restarts from zero before that strobe's result is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | End-of-integration strobe, one cycle |
| ch0_value | input | 16 | Channel-0 conversion result |
| thr_low | input | 16 | Low threshold {high byte, low byte} |
| thr_high | input | 16 | High threshold {high byte, low byte} |
| irq_ctrl | input | 8 | Control byte: bits 5:4 mode, bits 3:0 persistence |
| irq_ctrl_wr | input | 1 | Pulses in the first cycle in which irq_ctrl holds a new written value |
| clear_req | input | 1 | Clear bit of a command byte was written |
| dev_addr | input | 7 | Own 7-bit bus address |
| ara_done | input | 1 | Alert-response read address phase completed |
| ara_lost | input | 1 | Arbitration lost during that address phase |
| irq_n | output | 1 | Active-low interrupt (0 = drive low, 1 = release) |
| alert_resp | output | 8 | Alert response byte |

## Verification
The two events most likely to collide are a firing end-of-integration strobe and a clear request, since software clears at its own pace while conversions keep running. The bench drives both in the same cycle, once with persistence 1 and once with persistence 2. The first case checks that the new interrupt survives. The second checks that the counter restarts, so the pin only falls one strobe later. A reference model predicts the pin and the response byte on every cycle, and directed checks confirm the expected level after each scenario.

// File: rtl/thr_irq_pkg.sv
package thr_irq_pkg;

  typedef enum logic [1:0] {
    IRQ_OFF   = 2'b00,
    IRQ_LEVEL = 2'b01,
    IRQ_ALERT = 2'b10,
    IRQ_FORCE = 2'b11
  } irq_mode_e;

  localparam int unsigned CTRL_W = 8;
  localparam int unsigned MODE_W = 2;

  function automatic logic mode_is_alert(input irq_mode_e m);
    return (m == IRQ_ALERT) || (m == IRQ_FORCE);
  endfunction

endpackage

// File: rtl/thr_window_cmp.sv
module thr_window_cmp #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  output logic              outside
);

  logic below_or_at;
  logic above;

  always_comb begin
    below_or_at = (sample <= lo);
    above       = (sample > hi);
    outside     = below_or_at | above;
  end

endmodule

// File: rtl/thr_persist_ctr.sv
module thr_persist_ctr #(
  parameter int unsigned PERS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              outside,
  input  logic              restart,
  input  logic [PERS_W-1:0] persist,
  output logic              fire
);

  localparam logic [PERS_W-1:0] CNT_MAX = {PERS_W{1'b1}};

  logic [PERS_W-1:0] cnt_q;
  logic [PERS_W-1:0] cnt_d;
  logic [PERS_W-1:0] base;
  logic [PERS_W-1:0] inc;
  logic              cnt_en;

  always_comb begin
    base   = restart ? '0 : cnt_q;
    inc    = (base == CNT_MAX) ? CNT_MAX : base + 1'b1;
    cnt_en = strobe | restart;
    cnt_d  = cnt_q;
    if (strobe) begin
      cnt_d = outside ? inc : '0;
    end else if (restart) begin
      cnt_d = '0;
    end
    fire = strobe & ((persist == '0) | (outside & (inc >= persist)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R2: an in-window result empties the counter
  a_r2_in_window_zero: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !outside |=> cnt_q == '0);

  // R2: saturation, no wrap
  a_r2_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && outside && !restart && cnt_q == CNT_MAX |=> cnt_q == CNT_MAX);

  // R2: a clear alone empties the counter
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart && !strobe |=> cnt_q == '0);

  // R2: without strobe or clear the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe && !restart |=> $stable(cnt_q));

endmodule

// File: rtl/thr_irq_state.sv
module thr_irq_state (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic enabled,
  input  logic alert_mode,
  input  logic force_set,
  input  logic clear,
  input  logic ara_done,
  input  logic ara_lost,
  output logic pending
);

  logic pending_q;
  logic pending_d;
  logic set_ev;
  logic ara_ok;

  always_comb begin
    set_ev    = (fire & enabled) | force_set;
    ara_ok    = ara_done & ~ara_lost & alert_mode & pending_q;
    pending_d = set_ev | (pending_q & ~clear & ~ara_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
    end else begin
      pending_q <= pending_d;
    end
  end

  assign pending = pending_q;

  // R9: losing arbitration keeps the interrupt
  a_r9_lost_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q && ara_done && ara_lost && !clear |=> pending_q);

  // R7: pending holds until a clearing event
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q && !clear && !ara_done |=> pending_q);

  // R5: nothing sets the interrupt without a strobe or forced write
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !pending_q && !fire && !force_set |=> !pending_q);

  // R11: a firing strobe wins over a coincident clear
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fire && enabled && clear |=> pending_q);

endmodule

// File: rtl/thr_irq_unit.sv
module thr_irq_unit
  import thr_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PERS_W = 4,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] ch0_value,
  input  logic [DATA_W-1:0] thr_low,
  input  logic [DATA_W-1:0] thr_high,
  input  logic [7:0]        irq_ctrl,
  input  logic              irq_ctrl_wr,
  input  logic              clear_req,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              ara_done,
  input  logic              ara_lost,
  output logic              irq_n,
  output logic [ADDR_W:0]   alert_resp
);

  localparam int unsigned MODE_LSB = PERS_W;

  irq_mode_e         mode;
  logic [PERS_W-1:0] persist;
  logic              outside;
  logic              fire;
  logic              pending;
  logic              enabled;
  logic              alert_mode;
  logic              force_set;

  always_comb begin
    mode       = irq_mode_e'(irq_ctrl[MODE_LSB +: MODE_W]);
    persist    = irq_ctrl[PERS_W-1:0];
    enabled    = (mode != IRQ_OFF);
    alert_mode = mode_is_alert(mode);
    force_set  = irq_ctrl_wr & (mode == IRQ_FORCE);
  end

  thr_window_cmp #(.DATA_W(DATA_W)) u_cmp (
    .sample  (ch0_value),
    .lo      (thr_low),
    .hi      (thr_high),
    .outside (outside)
  );

  thr_persist_ctr #(.PERS_W(PERS_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (conv_done),
    .outside (outside),
    .restart (clear_req),
    .persist (persist),
    .fire    (fire)
  );

  thr_irq_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .enabled    (enabled),
    .alert_mode (alert_mode),
    .force_set  (force_set),
    .clear      (clear_req),
    .ara_done   (ara_done),
    .ara_lost   (ara_lost),
    .pending    (pending)
  );

  always_comb begin
    irq_n      = ~(pending & enabled);
    alert_resp = (pending & alert_mode) ? {dev_addr, 1'b0} : '0;
  end

  // R8: a forced write drives the pin on the next cycle
  a_r8_force: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ctrl_wr && irq_ctrl[MODE_LSB +: MODE_W] == 2'b11 && $stable(irq_ctrl)
    |=> (irq_n == (irq_ctrl[MODE_LSB +: MODE_W] == 2'b00)));

  // R4: with nonzero persistence an in-window strobe never raises a new interrupt
  a_r4_in_window_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && !outside && persist != '0 && !pending && !force_set |=> !pending);

endmodule

// File: tb/thr_irq_unit_test.sv
`timescale 1ns/1ps
module thr_irq_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        conv_done, irq_ctrl_wr, clear_req, ara_done, ara_lost;
  logic [15:0] ch0_value, thr_low, thr_high;
  logic [7:0]  irq_ctrl;
  logic [6:0]  dev_addr;
  logic        irq_n;
  logic [7:0]  alert_resp;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  thr_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .ch0_value(ch0_value),
    .thr_low(thr_low), .thr_high(thr_high), .irq_ctrl(irq_ctrl),
    .irq_ctrl_wr(irq_ctrl_wr), .clear_req(clear_req), .dev_addr(dev_addr),
    .ara_done(ara_done), .ara_lost(ara_lost), .irq_n(irq_n), .alert_resp(alert_resp)
  );

  // behavioural reference model
  int m_cnt;
  bit m_pend;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0;
      m_pend = 0;
    end else begin
      int md, pr, base, nc;
      bit out, fire, ara_ok;
      md  = irq_ctrl[5:4];
      pr  = irq_ctrl[3:0];
      out = (ch0_value <= thr_low) || (ch0_value > thr_high);
      base = clear_req ? 0 : m_cnt;
      fire = 0;
      if (conv_done) begin
        nc = out ? ((base + 1 > 15) ? 15 : base + 1) : 0;
        fire = (pr == 0) || (out && nc >= pr);
        m_cnt = nc;
      end else if (clear_req) begin
        m_cnt = 0;
      end
      ara_ok = ara_done && !ara_lost && (md >= 2) && m_pend;
      m_pend = (fire && md != 0) || (irq_ctrl_wr && md == 3) ||
               (m_pend && !clear_req && !ara_ok);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic exp_n;
      logic [7:0] exp_r;
      exp_n = !(m_pend && irq_ctrl[5:4] != 0);
      exp_r = (m_pend && irq_ctrl[5]) ? {dev_addr, 1'b0} : 8'h00;
      checks++;
      if (irq_n !== exp_n) begin
        errors++;
        $display("FAIL R7 model pin actual %0b expected %0b at %0t", irq_n, exp_n, $time);
      end
      checks++;
      if (alert_resp !== exp_r) begin
        errors++;
        $display("FAIL R10 model byte actual %02h expected %02h at %0t", alert_resp, exp_r, $time);
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit cv, input logic [15:0] v, input bit clr,
                       input bit wr, input bit ara, input bit lost);
    @(posedge clk); #1;
    conv_done = cv; ch0_value = v; clear_req = clr;
    irq_ctrl_wr = wr; ara_done = ara; ara_lost = lost;
    @(posedge clk); #1;
    conv_done = 0; clear_req = 0; irq_ctrl_wr = 0; ara_done = 0; ara_lost = 0;
    ch0_value = 16'd500;
  endtask

  task automatic strobe(input logic [15:0] v);
    pulse(1, v, 0, 0, 0, 0);
  endtask

  task automatic clr();
    pulse(0, 16'd500, 1, 0, 0, 0);
  endtask

  task automatic setctrl(input logic [7:0] c);
    @(posedge clk); #1; irq_ctrl = c;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; conv_done = 0; irq_ctrl_wr = 0; clear_req = 0; ara_done = 0; ara_lost = 0;
    ch0_value = 16'd500; thr_low = 16'd100; thr_high = 16'd1000;
    irq_ctrl = 8'h00; dev_addr = 7'h29;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(irq_n, 1, "R7 reset pin");
    chk(alert_resp, 8'h00, "R10 reset byte");

    // R1 window edges, level mode, persistence 1
    setctrl(8'h11);
    strobe(16'd500);  chk(irq_n, 1, "R1 inside");
    strobe(16'd100);  chk(irq_n, 0, "R1 low inclusive");
    chk(alert_resp, 8'h00, "R10 level no byte");
    repeat (4) @(posedge clk); #1;
    chk(irq_n, 0, "R7 hold");
    clr();            chk(irq_n, 1, "R7 clear");
    strobe(16'd1000); chk(irq_n, 1, "R1 high strict");
    strobe(16'd1001); chk(irq_n, 0, "R1 above high");
    clr();

    // R3 persistence 0
    setctrl(8'h10);
    strobe(16'd500);  chk(irq_n, 0, "R3 every cycle");
    clr();

    // R4 and R2 persistence 3
    setctrl(8'h13);
    strobe(16'd50); strobe(16'd50); chk(irq_n, 1, "R4 two of three");
    strobe(16'd500);                chk(irq_n, 1, "R2 in-window reset");
    strobe(16'd50); strobe(16'd50); chk(irq_n, 1, "R2 restarted count");
    strobe(16'd50);                 chk(irq_n, 0, "R4 third miss");
    clr();
    strobe(16'd50);                 chk(irq_n, 1, "R2 clear resets count");

    // R6 disabled output, R2 saturation
    clr();
    setctrl(8'h0F);
    for (int i = 0; i < 16; i++) strobe(16'd50);
    chk(irq_n, 1, "R6 disabled pin");
    chk(alert_resp, 8'h00, "R6 disabled byte");
    setctrl(8'h1F);
    strobe(16'd50);                 chk(irq_n, 0, "R2 saturated count");
    clr();

    // R8 forced, R9 and R10 alert response
    @(posedge clk); #1; irq_ctrl = 8'h30; irq_ctrl_wr = 1;
    @(posedge clk); #1; irq_ctrl_wr = 0;
    chk(irq_n, 0, "R8 forced");
    chk(alert_resp, 8'h52, "R10 address byte");
    pulse(0, 16'd500, 0, 0, 1, 1);  chk(irq_n, 0, "R9 lost keeps");
    pulse(0, 16'd500, 0, 0, 1, 0);  chk(irq_n, 1, "R9 ara clears");
    chk(alert_resp, 8'h00, "R10 idle byte");

    // alert mode from threshold
    setctrl(8'h21);
    strobe(16'd50);                 chk(irq_n, 0, "R9 alert set");
    pulse(0, 16'd500, 0, 0, 1, 0);  chk(irq_n, 1, "R9 alert cleared");

    // level mode ignores alert read
    setctrl(8'h11);
    strobe(16'd50);
    pulse(0, 16'd500, 0, 0, 1, 0);  chk(irq_n, 0, "R9 level ignores");
    clr();                          chk(irq_n, 1, "R5 clear");

    // R11 coincidence
    pulse(1, 16'd50, 1, 0, 0, 0);   chk(irq_n, 0, "R11 set wins");
    clr();
    setctrl(8'h12);
    strobe(16'd50);                 chk(irq_n, 1, "R11 first miss");
    pulse(1, 16'd50, 1, 0, 0, 0);   chk(irq_n, 1, "R11 count restarted");
    strobe(16'd50);                 chk(irq_n, 0, "R11 second miss");
    repeat (3) @(posedge clk); #1;

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule